// File: doc/BRIEF.md
# Difference-Weighted Moving Average Filter

This block smooths a stream of unsigned ADC samples from one sensor axis. It keeps the most recent samples in a sliding window. Each sample is stored with a weight of 1, 2 or 3. The weight depends on how far that sample stepped away from the sample accepted just before it. Small steps count as noise and get the lowest weight. Large steps count as real signal movement and get more weight. This lets a sharp transient show up in the output with less attenuation than a plain average would give it.

The output is the weighted sum of the window divided by the sum of the window's weights. The quotient is truncated toward zero. A multi-cycle divider computes this quotient. While the divider works, the block holds off new samples by driving its ready output low. Two programmable thresholds set the step sizes where the weight changes, measured in ADC counts.

Top module: `wma_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The first sample accepted after reset gets weight 1, so its output equals that sample.
- R3: The step is the absolute difference between a sample and the previously accepted sample. A step ≤ `thr_lo` gives weight 1. Otherwise, a step ≤ `thr_hi` gives weight 2. Any larger step gives weight 3. The thresholds are read in the cycle the sample is accepted.
- R4: The window holds the DEPTH (default 8) most recently accepted samples. Accepting a sample when the window is full drops the oldest sample and its weight.
- R5: Before DEPTH samples have been accepted, only the samples received so far contribute to either sum.
- R6: Every result is floor(Σ weight·sample / Σ weight) over the current window.
- R7: A sample is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after acceptance until the result appears on `out_valid`. Samples offered while `in_ready` is 0 are ignored. An ignored sample changes neither the window nor the previous-sample reference.
- R8: Each accepted sample produces exactly one `out_valid` pulse, one cycle long, with `out_value` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_sample | input | DATA_W | Unsigned ADC sample |
| in_ready | output | 1 | Block can accept a sample this cycle |
| thr_lo | input | DATA_W | Largest step that still gets weight 1 |
| thr_hi | input | DATA_W | Largest step that still gets weight 2 |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_value | output | DATA_W | Weighted average of the window |

## Verification
The hardest case to reach is an eviction where the outgoing entry has a different weight from the incoming one. Both sums must then move by different amounts in the same cycle. The stimulus table fills the window with small steps and then injects large jumps as the window wraps. This forces weight-1 entries to be replaced by weight-3 entries and the reverse. A second hard case is a sample offered while the divider is busy. The bench drives a full-scale value during that window. It then checks that the next result and the next weight choice still use the last sample that was actually accepted.

// File: rtl/wma_pkg.sv
package wma_pkg;
  typedef logic [1:0] weight_t;

  // Weight chosen from the absolute step; the first sample has no reference.
  function automatic weight_t pick_weight(input logic first, input logic [31:0] step,
                                          input logic [31:0] lo, input logic [31:0] hi);
    if (first)           return 2'd1;
    else if (step <= lo) return 2'd1;
    else if (step <= hi) return 2'd2;
    else                 return 2'd3;
  endfunction

  function automatic logic [31:0] abs_step(input logic [31:0] a, input logic [31:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/wma_weight.sv
module wma_weight #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] thr_lo,
  input  logic [DATA_W-1:0] thr_hi,
  output wma_pkg::weight_t  weight,
  output logic              first
);
  import wma_pkg::*;

  logic [DATA_W-1:0] prev_q;
  logic              have_q;
  logic [31:0]       step;

  assign first  = !have_q;
  assign step   = abs_step(32'(sample), 32'(prev_q));
  assign weight = pick_weight(first, step, 32'(thr_lo), 32'(thr_hi));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (push) begin
      prev_q <= sample;
      have_q <= 1'b1;
    end
  end

  // R3: weight stays within the three legal levels
  a_r3_weight_legal: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (weight != 2'd0));
  // R2: the first accepted sample after reset carries weight 1
  a_r2_first_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (push && first) |-> (weight == 2'd1));
endmodule

// File: rtl/wma_window.sv
module wma_window #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int SUM_W = DATA_W + AW + 2,
  localparam int WT_W  = $clog2(3 * DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] sample,
  input  wma_pkg::weight_t  weight,
  output logic [SUM_W-1:0]  val_sum,
  output logic [WT_W-1:0]   wt_sum,
  output logic [AW:0]       fill
);
  import wma_pkg::*;

  logic [DATA_W-1:0] smp_q [DEPTH];
  weight_t           wt_q  [DEPTH];
  logic [AW-1:0]     wr_q;
  logic [AW:0]       fill_q;
  logic [SUM_W-1:0]  sum_q;
  logic [WT_W-1:0]   wsum_q;

  logic              full;
  logic [SUM_W-1:0]  add_prod, sub_prod;
  logic [WT_W-1:0]   sub_wt;

  assign full     = (fill_q == (AW+1)'(DEPTH));
  assign add_prod = SUM_W'(sample) * SUM_W'(weight);
  assign sub_prod = full ? SUM_W'(smp_q[wr_q]) * SUM_W'(wt_q[wr_q]) : '0;
  assign sub_wt   = full ? WT_W'(wt_q[wr_q]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        smp_q[i] <= '0;
        wt_q[i]  <= '0;
      end
      wr_q   <= '0;
      fill_q <= '0;
      sum_q  <= '0;
      wsum_q <= '0;
    end else if (push) begin
      smp_q[wr_q] <= sample;
      wt_q[wr_q]  <= weight;
      wr_q        <= wr_q + 1'b1;
      if (!full) fill_q <= fill_q + 1'b1;
      sum_q  <= sum_q - sub_prod + add_prod;
      wsum_q <= wsum_q - sub_wt + WT_W'(weight);
    end
  end

  assign val_sum = sum_q;
  assign wt_sum  = wsum_q;
  assign fill    = fill_q;

  // R5: fill count never passes the window depth
  a_r5_fill_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= (AW+1)'(DEPTH));
  // R4: weight total lies between one and three per stored entry
  a_r4_wsum_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(wsum_q) >= 32'(fill_q)) && (32'(wsum_q) <= 3 * 32'(fill_q)));
  // R6: value total bounded by the weight total times full scale
  a_r6_sum_bound: assert property (@(posedge clk) disable iff (!rst_n)
    64'(sum_q) <= 64'(wsum_q) * ((64'd1 << DATA_W) - 64'd1));
endmodule

// File: rtl/wma_divider.sv
module wma_divider #(
  parameter int NUM_W = 17,
  parameter int DEN_W = 5,
  parameter int OUT_W = 12,
  localparam int CNT_W = $clog2(NUM_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [OUT_W-1:0] quot
);
  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [DEN_W:0]   rem_sh;
  logic             fits;

  assign rem_sh = {rem_q, quo_q[NUM_W-1]};
  assign fits   = (rem_sh >= {1'b0, den_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        quo_q <= num;
        rem_q <= '0;
        den_q <= den;
        cnt_q <= CNT_W'(NUM_W);
      end else if (cnt_q != '0) begin
        quo_q <= {quo_q[NUM_W-2:0], fits};
        rem_q <= fits ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) done_q <= 1'b1;
      end
    end
  end

  assign busy = (cnt_q != '0);
  assign done = done_q;
  assign quot = quo_q[OUT_W-1:0];

  // R6: a divide never starts with an empty weight total
  a_r6_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (den != '0));
  // R6: the weighted average always fits the sample width
  a_r6_quot_fits: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (quo_q[NUM_W-1:OUT_W] == '0));
  // R6: remainder stays below the divisor after every step
  a_r6_rem_below: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < den_q));
endmodule

// File: rtl/wma_filter.sv
module wma_filter #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int SUM_W = DATA_W + AW + 2,
  localparam int WT_W  = $clog2(3 * DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  output logic              in_ready,
  input  logic [DATA_W-1:0] thr_lo,
  input  logic [DATA_W-1:0] thr_hi,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_value
);
  import wma_pkg::*;

  logic             accept;
  logic             start_q;
  logic             div_busy;
  logic             div_done;
  weight_t          cur_weight;
  logic             is_first;
  logic [SUM_W-1:0] val_sum;
  logic [WT_W-1:0]  wt_sum;
  logic [AW:0]      fill;

  assign in_ready = !(start_q || div_busy);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= accept;
  end

  wma_weight #(.DATA_W(DATA_W)) u_weight (
    .clk(clk), .rst_n(rst_n), .push(accept), .sample(in_sample),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .weight(cur_weight), .first(is_first)
  );

  wma_window #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_window (
    .clk(clk), .rst_n(rst_n), .push(accept), .sample(in_sample),
    .weight(cur_weight), .val_sum(val_sum), .wt_sum(wt_sum), .fill(fill)
  );

  wma_divider #(.NUM_W(SUM_W), .DEN_W(WT_W), .OUT_W(DATA_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start_q), .num(val_sum), .den(wt_sum),
    .busy(div_busy), .done(div_done), .quot(out_value)
  );

  assign out_valid = div_done;

  // R7: the cycle after an acceptance never accepts again
  a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R8: result strobe lasts a single cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R2: the first-sample flag only appears with an empty window
  a_r2_empty_on_first: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_first) |-> (fill == '0));
  // R8: a result is only produced while no new sample was taken in between
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !start_q);
endmodule

// File: tb/test_wma_filter.sv
`timescale 1ns/1ps
module test_wma_filter;
  localparam int DW = 12;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_sample = '0;
  logic [DW-1:0] thr_lo = '0;
  logic [DW-1:0] thr_hi = '0;
  logic in_ready, out_valid;
  logic [DW-1:0] out_value;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  wma_filter #(.DATA_W(DW), .DEPTH(DEPTH)) i_wma_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_ready(in_ready), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .out_valid(out_valid), .out_value(out_value)
  );

  // reference model state: accepted samples only
  int m_smp [DEPTH];
  int m_wt  [DEPTH];
  int m_cnt, m_prev;

  // sample, thr_lo, thr_hi
  localparam int VEC [18][3] = '{
    '{1000, 4, 40}, '{1002, 4, 40}, '{1001, 4, 40}, '{1020, 4, 40},
    '{1100, 4, 40}, '{1099, 4, 40}, '{ 900, 4, 40}, '{ 905, 4, 40},
    '{3000, 4, 40}, '{3001, 4, 40}, '{ 100, 4, 40}, '{ 130, 4, 40},
    '{ 130, 0,  0}, '{4095, 0,  0}, '{   0, 50, 50}, '{  50, 50, 50},
    '{  51, 0, 2000}, '{2100, 0, 2000}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_weight(input int s, input int lo, input int hi);
    int d;
    if (m_cnt == 0) return 1;
    d = s - m_prev;
    if (d < 0) d = -d;
    if (d > hi && d > lo) return 3;
    if (d > lo) return 2;
    return 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin m_smp[i] = 0; m_wt[i] = 0; end
    m_cnt = 0; m_prev = 0;
  endtask

  function automatic int model_push(input int s, input int lo, input int hi);
    int w, num, den;
    w = model_weight(s, lo, hi);
    for (int i = DEPTH - 1; i > 0; i--) begin
      m_smp[i] = m_smp[i-1]; m_wt[i] = m_wt[i-1];
    end
    m_smp[0] = s; m_wt[0] = w;
    m_cnt++; m_prev = s;
    num = 0; den = 0;
    for (int i = 0; i < DEPTH; i++) begin
      num += m_smp[i] * m_wt[i]; den += m_wt[i];
    end
    return num / den;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic send(input int s, input int lo, input int hi, input string req, input bit junk);
    int exp, waitc;
    exp = model_push(s, lo, hi);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_sample = DW'(s); thr_lo = DW'(lo); thr_hi = DW'(hi);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R7 ready low after accept", int'(in_ready), 0);
    if (junk) begin
      in_valid = 1'b1; in_sample = '1;
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
    end
    waitc = 0;
    while (!out_valid && waitc < 200) begin @(negedge clk); waitc++; end
    chk(out_valid == 1'b1, "R8 result strobe", int'(out_valid), 1);
    chk(int'(out_value) == exp, req, int'(out_value), exp);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 strobe one cycle", int'(out_valid), 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // table walk: R3 weights, R4 eviction, R5 partial fill, R6 quotient
    foreach (VEC[i]) begin
      send(VEC[i][0], VEC[i][1], VEC[i][2],
           (i < DEPTH) ? "R5 R6 partial window" : "R4 R6 sliding window", 1'b0);
    end

    // R2: first sample after reset passes through unchanged, huge step ignored for it
    do_reset();
    send(4000, 10, 100, "R2 first sample weight one", 1'b0);
    send(0, 10, 100, "R3 weight three step", 1'b0);
    send(60, 10, 100, "R3 weight two step", 1'b0);
    send(65, 10, 100, "R3 weight one step", 1'b0);
    // R3 boundaries: step exactly at each threshold
    send(75, 10, 100, "R3 step equal thr_lo", 1'b0);
    send(175, 10, 100, "R3 step equal thr_hi", 1'b0);
    send(276, 10, 100, "R3 step above thr_hi", 1'b0);

    // R7: full-scale sample offered while busy must be ignored
    do_reset();
    send(200, 5, 50, "R7 before ignored offer", 1'b1);
    send(204, 5, 50, "R7 ignored offer leaves window and reference", 1'b1);
    send(230, 5, 50, "R7 reference still last accepted", 1'b0);

    // R4: constant fill then wrap with large jumps
    do_reset();
    for (int k = 0; k < DEPTH; k++) send(500, 2, 20, "R5 constant fill", 1'b0);
    for (int k = 0; k < DEPTH + 2; k++)
      send((k % 2) ? 500 : 3500, 2, 20, "R4 wrap mixed weights", 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule